// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a memory-mapped watchdog with two escalation stages. It watches a free-running 64-bit system count supplied from outside. Software arms it by setting an enable bit and a 48-bit period. The block then holds a 64-bit deadline equal to the count at arming plus the period. If software lets the deadline pass, the first stage sets a status flag, raises an interrupt and moves the deadline one full period on. If the second deadline also passes, the second stage sets another flag and raises a reset request.

Accesses are single-cycle and 32 bits wide. A frame-select input chooses between two register frames. The control frame holds the enable/status word, the two period words, the two deadline words and an identification word. The refresh frame holds a kick register and the same identification word. Any write to the kick register restarts the period and clears both stages. Read data is combinational and is valid while a read request is present.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, the control word, both period words and both deadline words read zero, `irq_o` and `rst_req_o` are low, and the identification word (byte 0x1C) reads `ID_VALUE` from both frames.
- R2: Writing the control word (control frame, byte 0x00) stores only data bit 0 as enable. It clears both status bits and deasserts `irq_o`. When the written enable is 1, it loads the deadline with the present count plus the period. The control word reads {ws1, ws0, en} in bits 2:0 and zero above.
- R3: The period is 48 bits. The word at 0x04 holds bits 31:0. The word at 0x08 stores only its data bits 15:0 as bits 47:32 and reads zero above them. A write to either word clears both status bits and deasserts `irq_o`. It reloads the deadline from the new period only while enabled.
- R4: Any write to the kick register (refresh frame, byte 0x00) clears both status bits, whatever the data. While enabled, it also reloads the deadline from the count plus the period. It leaves `irq_o` unchanged. A read of the kick register returns zero and changes nothing.
- R5: When enabled, if the count is at or above the deadline (unsigned) and ws0 is clear, the block sets ws0, asserts `irq_o` and loads the deadline with the count plus the period.
- R6: When enabled, if the count is at or above the deadline while ws0 is set, the block sets ws1 and drives `rst_req_o` high. The deadline is left unchanged.
- R7: While disabled, no expiry is detected: the status bits and `irq_o` do not change unless a register is written.
- R8: The deadline words (low word 0x0C, high word 0x10) can be written directly. Such writes change neither the status bits nor `irq_o`.
- R9: An access at an unaligned address (bits 1:0 not zero) or at an undefined offset reads zero, and a write there changes nothing. This includes writes to the identification word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_cnt_i | input | 64 | Free-running system count |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_rfr_i | input | 1 | Frame select: 1 = refresh frame, 0 = control frame |
| bus_addr_i | input | ADDR_W | Byte offset within the frame |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when no read is requested |
| irq_o | output | 1 | First-stage interrupt |
| rst_req_o | output | 1 | Second-stage reset request (follows ws1) |

## Verification
The bench sweeps small periods against count step sizes of one to three. This exposes a design that tests for an exact match instead of "at or above": with steps larger than one, such a design would skip the deadline and never escalate. The bench predicts the exact cycles of both expiries arithmetically, so an off-by-one in the re-arm would move the second expiry. Other cases target specific faults. A deadline written below the count while ws0 is set should escalate only to the second stage; a design that re-armed there would hide the reset request. The kick must clear the status but leave the interrupt alone. Period writes made while disabled must not move the deadline. Unaligned, undefined and identification-word writes must not leak into any register.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int unsigned CNT_W = 64;
    localparam int unsigned REG_W = 32;

    // control frame byte offsets
    localparam int unsigned OFS_CTRL  = 'h00;
    localparam int unsigned OFS_PLO   = 'h04;
    localparam int unsigned OFS_PHI   = 'h08;
    localparam int unsigned OFS_CLO   = 'h0C;
    localparam int unsigned OFS_CHI   = 'h10;
    localparam int unsigned OFS_IDENT = 'h1C;
    // refresh frame byte offset
    localparam int unsigned OFS_KICK  = 'h00;

    typedef struct packed {
        logic ctrl;
        logic per_lo;
        logic per_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic kick;
    } wr_strb_t;

endpackage

// File: rtl/wdt2_regdec.sv
module wdt2_regdec
    import wdt2_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned OFS_W    = 48,
    parameter logic [31:0] ID_VALUE = 32'h5D0A_0001
) (
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic                 rfr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 en_i,
    input  logic                 ws0_i,
    input  logic                 ws1_i,
    input  logic [OFS_W-1:0]     per_i,
    input  logic [CNT_W-1:0]     cmp_i,
    output wr_strb_t             strb_o,
    output logic [REG_W-1:0]     rdata_o
);

    localparam int unsigned HI_W = OFS_W - REG_W;

    logic wr_c;
    logic wr_r;
    logic rd_c;
    logic rd_r;

    assign wr_c = req_i &  we_i & ~rfr_i;
    assign wr_r = req_i &  we_i &  rfr_i;
    assign rd_c = req_i & ~we_i & ~rfr_i;
    assign rd_r = req_i & ~we_i &  rfr_i;

    always_comb begin
        strb_o        = '0;
        strb_o.ctrl   = wr_c && (addr_i == ADDR_W'(OFS_CTRL));
        strb_o.per_lo = wr_c && (addr_i == ADDR_W'(OFS_PLO));
        strb_o.per_hi = wr_c && (addr_i == ADDR_W'(OFS_PHI));
        strb_o.cmp_lo = wr_c && (addr_i == ADDR_W'(OFS_CLO));
        strb_o.cmp_hi = wr_c && (addr_i == ADDR_W'(OFS_CHI));
        strb_o.kick   = wr_r && (addr_i == ADDR_W'(OFS_KICK));
    end

    always_comb begin
        rdata_o = '0;
        if (rd_c) begin
            case (addr_i)
                ADDR_W'(OFS_CTRL):  rdata_o = {{(REG_W-3){1'b0}}, ws1_i, ws0_i, en_i};
                ADDR_W'(OFS_PLO):   rdata_o = per_i[REG_W-1:0];
                ADDR_W'(OFS_PHI):   rdata_o = REG_W'(per_i[OFS_W-1:REG_W]);
                ADDR_W'(OFS_CLO):   rdata_o = cmp_i[REG_W-1:0];
                ADDR_W'(OFS_CHI):   rdata_o = cmp_i[CNT_W-1:REG_W];
                ADDR_W'(OFS_IDENT): rdata_o = ID_VALUE;
                default:            rdata_o = '0;
            endcase
        end else if (rd_r) begin
            // the kick register reads as zero
            if (addr_i == ADDR_W'(OFS_IDENT)) begin
                rdata_o = ID_VALUE;
            end
        end
    end

    if (HI_W > REG_W) begin : g_bad_width
        initial $error("period upper word wider than a register");
    end

endmodule

// File: rtl/wdt2_timebase.sv
module wdt2_timebase
    import wdt2_pkg::*;
#(
    parameter int unsigned OFS_W = 48
) (
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [OFS_W-1:0] per_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] reload_o
);

    // unsigned magnitude test so a count that jumps past the deadline still fires
    assign hit_o    = en_i && (cnt_i >= cmp_i);
    assign reload_o = cnt_i + CNT_W'(per_i);

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
    import wdt2_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned OFS_W    = 48,
    parameter logic [31:0] ID_VALUE = 32'h5D0A_0001
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [63:0]       sys_cnt_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic              bus_rfr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int unsigned HI_W = OFS_W - REG_W;

    typedef struct packed {
        logic             en;
        logic             ws0;
        logic             ws1;
        logic             irq;
        logic [OFS_W-1:0] per;
        logic [CNT_W-1:0] cmp;
    } wdt_state_t;

    wdt_state_t       state_d, state_q;
    wr_strb_t         strb;
    logic [OFS_W-1:0] per_sel;
    logic             hit;
    logic [CNT_W-1:0] reload;

    wdt2_regdec #(
        .ADDR_W   (ADDR_W),
        .OFS_W    (OFS_W),
        .ID_VALUE (ID_VALUE)
    ) i_regdec (
        .req_i   (bus_req_i),
        .we_i    (bus_we_i),
        .rfr_i   (bus_rfr_i),
        .addr_i  (bus_addr_i),
        .en_i    (state_q.en),
        .ws0_i   (state_q.ws0),
        .ws1_i   (state_q.ws1),
        .per_i   (state_q.per),
        .cmp_i   (state_q.cmp),
        .strb_o  (strb),
        .rdata_o (bus_rdata_o)
    );

    // the period the reload adder sees already contains a word being written
    always_comb begin
        per_sel = state_q.per;
        if (strb.per_lo) begin
            per_sel[REG_W-1:0] = bus_wdata_i;
        end else if (strb.per_hi) begin
            per_sel[OFS_W-1:REG_W] = bus_wdata_i[HI_W-1:0];
        end
    end

    wdt2_timebase #(
        .OFS_W (OFS_W)
    ) i_timebase (
        .en_i     (state_q.en),
        .cnt_i    (sys_cnt_i),
        .cmp_i    (state_q.cmp),
        .per_i    (per_sel),
        .hit_o    (hit),
        .reload_o (reload)
    );

    always_comb begin
        state_d     = state_q;
        state_d.per = per_sel;
        if (strb.ctrl) begin
            state_d.en  = bus_wdata_i[0];
            state_d.ws0 = 1'b0;
            state_d.ws1 = 1'b0;
            state_d.irq = 1'b0;
            if (bus_wdata_i[0]) begin
                state_d.cmp = reload;
            end
        end else if (strb.per_lo || strb.per_hi) begin
            state_d.ws0 = 1'b0;
            state_d.ws1 = 1'b0;
            state_d.irq = 1'b0;
            if (state_q.en) begin
                state_d.cmp = reload;
            end
        end else if (strb.cmp_lo) begin
            state_d.cmp[REG_W-1:0] = bus_wdata_i;
        end else if (strb.cmp_hi) begin
            state_d.cmp[CNT_W-1:REG_W] = bus_wdata_i;
        end else if (strb.kick) begin
            state_d.ws0 = 1'b0;
            state_d.ws1 = 1'b0;
            if (state_q.en) begin
                state_d.cmp = reload;
            end
        end else if (hit) begin
            if (!state_q.ws0) begin
                state_d.ws0 = 1'b1;
                state_d.irq = 1'b1;
                state_d.cmp = reload;
            end else begin
                state_d.ws1 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o     = state_q.irq;
    assign rst_req_o = state_q.ws1;

endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker
    import wdt2_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_req_i,
    input logic              bus_we_i,
    input logic              bus_rfr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              irq_o,
    input logic              rst_req_o,
    input logic              en_i,
    input logic              ws0_i,
    input logic              ws1_i,
    input logic [CNT_W-1:0]  cmp_i
);

    logic kick_wr;
    logic cmp_wr;

    assign kick_wr = bus_req_i && bus_we_i && bus_rfr_i && (bus_addr_i == ADDR_W'(OFS_KICK));
    assign cmp_wr  = bus_req_i && bus_we_i && !bus_rfr_i &&
                     ((bus_addr_i == ADDR_W'(OFS_CLO)) || (bus_addr_i == ADDR_W'(OFS_CHI)));

    assert_irq_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(en_i));

    assert_reset_after_stage1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> $past(ws0_i));

    assert_kick_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_wr |=> (!ws0_i && !ws1_i));

    assert_cmp_write_keeps_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_wr |=> ($stable(irq_o) && $stable(ws0_i) && $stable(ws1_i)));

    assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !(bus_req_i && bus_we_i)) |=> ($stable(ws0_i) && $stable(ws1_i) && $stable(irq_o)));

    assert_read_no_effect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && !bus_we_i && !en_i) |=> $stable(cmp_i));

endmodule

bind twostage_wdt wdt2_checker #(.ADDR_W(ADDR_W)) i_wdt2_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_rfr_i  (bus_rfr_i),
    .bus_addr_i (bus_addr_i),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .en_i       (state_q.en),
    .ws0_i      (state_q.ws0),
    .ws1_i      (state_q.ws1),
    .cmp_i      (state_q.cmp)
);

// File: tb/test_twostage_wdt.sv
`timescale 1ns/1ps
module test_twostage_wdt;

    localparam logic [31:0] ID = 32'h5D0A_0001;
    localparam int A_CTRL = 'h00, A_PLO = 'h04, A_PHI = 'h08, A_CLO = 'h0C,
                   A_CHI = 'h10, A_ID = 'h1C, A_KICK = 'h00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        req = 1'b0, we = 1'b0, rfr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rreq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    twostage_wdt i_twostage_wdt (
        .clk_i(clk), .rst_ni(rst_n), .sys_cnt_i(cnt),
        .bus_req_i(req), .bus_we_i(we), .bus_rfr_i(rfr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .rst_req_o(rreq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic f, input int a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; rfr = f; addr = a[11:0]; wdata = d;
        @(posedge clk);
        #1;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic f, input int a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; rfr = f; addr = a[11:0];
        #1;
        d = rdata;
        @(posedge clk);
        #1;
        req = 1'b0;
    endtask

    task automatic rd_cmp(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(1'b0, A_CLO, lo);
        rd(1'b0, A_CHI, hi);
        v = {hi, lo};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    initial begin
        logic [31:0] r;
        logic [63:0] c64;
        logic [63:0] per;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rreq, 0);
        rd(0, A_CTRL, r); chk("R1 ctrl", r, 0);
        rd(0, A_PLO, r);  chk("R1 per lo", r, 0);
        rd(0, A_PHI, r);  chk("R1 per hi", r, 0);
        rd_cmp(c64);      chk("R1 cmp", c64, 0);
        rd(0, A_ID, r);   chk("R1 id control frame", r, ID);
        rd(1, A_ID, r);   chk("R1 id refresh frame", r, ID);

        // R3: period words, written while disabled
        cnt = 64'h100;
        wr(0, A_PHI, 32'hFFFF_1234);
        rd(0, A_PHI, r); chk("R3 per hi keeps 16 bits", r, 32'h1234);
        wr(0, A_PLO, 32'h89AB_CDEF);
        rd(0, A_PLO, r); chk("R3 per lo", r, 32'h89AB_CDEF);
        rd_cmp(c64); chk("R3 no reload while disabled", c64, 0);
        per = 64'h1234_89AB_CDEF;

        // R2: control word
        wr(0, A_CTRL, 32'hFFFF_FFFE);
        rd(0, A_CTRL, r); chk("R2 only bit0 stored", r, 0);
        wr(0, A_CTRL, 32'hFFFF_FFFF);
        rd(0, A_CTRL, r); chk("R2 enable", r, 1);
        rd_cmp(c64); chk("R2 arm cmp", c64, 64'h100 + per);

        // R4: kick register
        rd(1, A_KICK, r); chk("R4 kick reads zero", r, 0);
        rd_cmp(c64); chk("R4 read no effect", c64, 64'h100 + per);
        cnt = 64'h5000;
        wr(1, A_KICK, 32'hDEAD_BEEF);
        rd_cmp(c64); chk("R4 kick reloads", c64, 64'h5000 + per);

        // R8 then R5: direct deadline writes, then first expiry
        cnt = 64'h6000;
        wr(0, A_CLO, 32'h0000_6003);
        wr(0, A_CHI, 32'h0);
        rd_cmp(c64); chk("R8 cmp direct write", c64, 64'h6003);
        chk("R8 irq untouched", irq, 0);
        cnt = 64'h6010;
        idle(3);
        chk("R5 irq", irq, 1);
        chk("R5 no reset yet", rreq, 0);
        rd(0, A_CTRL, r); chk("R5 ws0 set", r, 3);
        rd_cmp(c64); chk("R5 rearm cmp", c64, 64'h6010 + per);
        wr(0, A_CLO, 32'h5);
        chk("R8 irq kept", irq, 1);
        rd(0, A_CTRL, r); chk("R8 status kept", r, 3);

        // R6: second expiry
        wr(0, A_CHI, 32'h0);
        idle(2);
        rd(0, A_CTRL, r); chk("R6 ws1 set", r, 7);
        chk("R6 reset request", rreq, 1);
        rd_cmp(c64); chk("R6 cmp not moved", c64, 64'h5);

        // R4: kick clears stages, interrupt stays
        wr(1, A_KICK, 32'h0);
        rd(0, A_CTRL, r); chk("R4 kick clears status", r, 1);
        chk("R4 reset request dropped", rreq, 0);
        chk("R4 irq unchanged by kick", irq, 1);
        rd_cmp(c64); chk("R4 kick rearm", c64, 64'h6010 + per);
        wr(0, A_CTRL, 32'h1);
        chk("R2 ctrl write clears irq", irq, 0);

        // R7: disabled with a deadline already passed
        wr(0, A_CTRL, 32'h0);
        wr(0, A_CLO, 32'h0);
        wr(0, A_CHI, 32'h0);
        for (int i = 0; i < 5; i++) begin
            cnt = cnt + 64'd7;
            idle(1);
        end
        rd(0, A_CTRL, r); chk("R7 status quiet", r, 0);
        chk("R7 irq quiet", irq, 0);
        chk("R7 reset quiet", rreq, 0);

        // R9: bad accesses
        wr(0, A_CTRL + 1, 32'h1);
        rd(0, A_CTRL, r); chk("R9 unaligned ctrl write", r, 0);
        wr(0, A_PLO + 2, 32'h0);
        rd(0, A_PLO, r); chk("R9 unaligned period write", r, 32'h89AB_CDEF);
        wr(0, 'h40, 32'hFFFF_FFFF);
        rd(0, 'h40, r); chk("R9 undefined read", r, 0);
        rd(0, A_PLO + 1, r); chk("R9 unaligned read", r, 0);
        rd(1, 'h04, r); chk("R9 refresh undefined read", r, 0);
        wr(0, A_ID, 32'h0);
        rd(0, A_ID, r); chk("R9 id not writable", r, ID);
        rd_cmp(c64); chk("R9 cmp untouched", c64, 0);

        // R5/R6 sweep: period N, count step s
        for (int n = 0; n <= 5; n++) begin
            for (int s = 1; s <= 3; s++) begin
                int j1, j2;
                j1 = (n + s - 1) / s; if (j1 < 1) j1 = 1;
                j2 = j1 + j1;
                wr(0, A_CTRL, 32'h0);
                wr(0, A_PHI, 32'h0);
                wr(0, A_PLO, n);
                cnt = 64'h1_0000 + 64'(n * 64 + s);
                wr(0, A_CTRL, 32'h1);
                for (int j = 1; j <= j2 + 1; j++) begin
                    cnt = cnt + 64'(s);
                    @(posedge clk);
                    #1;
                    chk($sformatf("R5 sweep n=%0d s=%0d j=%0d irq", n, s, j), irq, (j >= j1));
                    chk($sformatf("R6 sweep n=%0d s=%0d j=%0d rst", n, s, j), rreq, (j >= j2));
                end
                rd(0, A_CTRL, r);
                chk($sformatf("R6 sweep n=%0d s=%0d ctrl", n, s), r, 7);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule